// File: doc/BRIEF.md
# Two-Port Word Memory with Collision Arbitration

This block is a word-organised memory with two fully independent access ports, called left and right, that share one clock. Each port has its own address, select, write strobe, output enable and two byte-lane enables. Either port can read or write any word in any cycle. Both ports may read the same word together without interference. Each port can write or read just the upper or lower half of a word.

When both ports select the same word in one cycle and at least one of them writes, an arbiter picks one winner. It raises a busy flag toward the loser, and the loser's write is dropped. A port that already held the word in the previous cycle beats one that has just arrived. When both arrive together, the left port wins. A master/slave select lets several instances sit side by side to form a wider word. In master mode the instance drives its own busy decisions. In slave mode it drives nothing and obeys busy inputs from the master, so every slice drops the same write.

Reads have one cycle of latency. Write data is committed on the clock edge, and a read in the same cycle returns the word as it was before that edge. The depth is 2^ADDR_W words. ADDR_W = 13 gives the full 8192-word array, and the default is kept smaller for elaboration.

Top module: `dpram_arb`

## Requirements
- R1: A word written through either port is returned by a later read of that address through either port, on `*_rdata` in the cycle after the read is issued. While that port's output enable is low, its `*_rdata` reads as zero.
- R2: Two reads of the same address in the same cycle both return the stored word, and neither busy output rises.
- R3: Upper-byte enable covers bits [2*LANE_W-1:LANE_W] and lower-byte enable covers bits [LANE_W-1:0]. A write changes only the enabled lanes. A read returns zero in any lane that was not enabled when the read was issued.
- R4: A collision exists only when both selects are high, the addresses are equal and at least one port writes. In every other cycle both busy outputs are low.
- R5: If one port was selected at the same address in the previous cycle and the other port was not, the first port wins the collision and the newcomer gets busy.
- R6: When neither port held the address in the previous cycle, the left port wins and `r_busy_out` rises. In master mode exactly one busy output is high during a collision.
- R7: Busy is valid combinationally in the cycle of the collision. It stays with the same loser while the collision persists with unchanged addresses, and it is low in the first cycle after the collision ends.
- R8: A write from the losing port is not committed, and the winning port's write is committed.
- R9: A read from the losing port still returns the word as stored before that cycle's edge.
- R10: With `master_sel` high the busy outputs carry the arbiter decision and the busy inputs are ignored. With `master_sel` low both busy outputs stay low, a high busy input suppresses that port's write, and it leaves that port's reads unaffected.
- R11: During and right after reset both busy outputs are low and both read outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | 1: drive busy from local arbiter; 0: take busy from inputs |
| l_cs | input | 1 | Left port select |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_oe | input | 1 | Left output enable |
| l_ub | input | 1 | Left upper-byte enable |
| l_lb | input | 1 | Left lower-byte enable |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 2*LANE_W | Left write data |
| l_rdata | output | 2*LANE_W | Left read data |
| l_busy_in | input | 1 | Left busy from master (slave mode) |
| l_busy_out | output | 1 | Left lost arbitration (master mode) |
| r_cs | input | 1 | Right port select |
| r_we | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_ub | input | 1 | Right upper-byte enable |
| r_lb | input | 1 | Right lower-byte enable |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 2*LANE_W | Right write data |
| r_rdata | output | 2*LANE_W | Right read data |
| r_busy_in | input | 1 | Right busy from master (slave mode) |
| r_busy_out | output | 1 | Right lost arbitration (master mode) |

## Verification
A wrong arbitration state shows up on the busy outputs in the same cycle as the collision. A stale previous-address or previous-winner register makes the wrong port lose, and the loser flips partway through a held collision. A wrong write-suppression decision stays in the array unseen until the word is read back, one cycle after the read is issued. The sweeps therefore read back each contested word right after the collision. A wrong lane mask shows on the very next read of that word, as a corrupted or non-zero byte.

// File: rtl/dparb_pkg.sv
package dparb_pkg;

  typedef enum logic {
    WIN_LEFT  = 1'b0,
    WIN_RIGHT = 1'b1
  } win_e;

  // A collision needs both ports selected on one word with a writer present.
  function automatic logic is_clash(input logic cs_a, input logic cs_b,
                                    input logic we_a, input logic we_b,
                                    input logic same_word);
    return cs_a & cs_b & same_word & (we_a | we_b);
  endfunction

  // Winner choice: keep the old winner while a collision is held, otherwise
  // the port that was already parked on the word wins, ties go left.
  function automatic win_e pick_winner(input logic hold, input win_e prior,
                                       input logic parked_l, input logic parked_r);
    if (hold)                  return prior;
    if (parked_r && !parked_l) return WIN_RIGHT;
    return WIN_LEFT;
  endfunction

endpackage

// File: rtl/dparb_arbiter.sv
module dparb_arbiter #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_l,
  input  logic              cs_r,
  input  logic              we_l,
  input  logic              we_r,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  output logic              clash_o,
  output logic              lose_l_o,
  output logic              lose_r_o
);
  import dparb_pkg::*;

  logic              prev_cs_l, prev_cs_r, prev_clash;
  logic [ADDR_W-1:0] prev_addr_l, prev_addr_r;
  win_e              prev_win, win;
  logic              parked_l, parked_r, hold;

  assign clash_o  = is_clash(cs_l, cs_r, we_l, we_r, addr_l == addr_r);
  assign parked_l = cs_l & prev_cs_l & (addr_l == prev_addr_l);
  assign parked_r = cs_r & prev_cs_r & (addr_r == prev_addr_r);
  assign hold     = clash_o & prev_clash & parked_l & parked_r;
  assign win      = pick_winner(hold, prev_win, parked_l, parked_r);
  assign lose_l_o = clash_o & (win == WIN_RIGHT);
  assign lose_r_o = clash_o & (win == WIN_LEFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cs_l   <= 1'b0;
      prev_cs_r   <= 1'b0;
      prev_addr_l <= '0;
      prev_addr_r <= '0;
      prev_clash  <= 1'b0;
      prev_win    <= WIN_LEFT;
    end else begin
      prev_cs_l   <= cs_l;
      prev_cs_r   <= cs_r;
      prev_addr_l <= addr_l;
      prev_addr_r <= addr_r;
      prev_clash  <= clash_o;
      prev_win    <= clash_o ? win : WIN_LEFT;
    end
  end

endmodule

// File: rtl/dparb_port.sv
module dparb_port #(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs,
  input  logic                we,
  input  logic                oe,
  input  logic                ub,
  input  logic                lb,
  input  logic                block,
  input  logic [2*LANE_W-1:0] word_q,
  output logic                wr_fire,
  output logic                rd_fire,
  output logic [2*LANE_W-1:0] wr_mask,
  output logic [2*LANE_W-1:0] rdata
);
  localparam int DATA_W = 2 * LANE_W;

  function automatic logic [DATA_W-1:0] lane_mask(input logic hi, input logic lo);
    return {{LANE_W{hi}}, {LANE_W{lo}}};
  endfunction

  logic [DATA_W-1:0] rd_mask_q;

  assign wr_fire = cs & we & (ub | lb) & ~block;
  assign rd_fire = cs & ~we;
  assign wr_mask = lane_mask(ub, lb);
  assign rdata   = oe ? (word_q & rd_mask_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_mask_q <= '0;
    else if (rd_fire) rd_mask_q <= lane_mask(ub, lb);
  end

endmodule

// File: rtl/dparb_array.sv
module dparb_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic [1:0]                  wr,
  input  logic [1:0]                  rd,
  input  logic [1:0][ADDR_W-1:0]      addr,
  input  logic [1:0][DATA_W-1:0]      wdata,
  input  logic [1:0][DATA_W-1:0]      mask,
  output logic [1:0][DATA_W-1:0]      q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (wr[p]) mem[addr[p]] <= (mem[addr[p]] & ~mask[p]) | (wdata[p] & mask[p]);
      if (rd[p]) q[p] <= mem[addr[p]];
    end
  end

endmodule

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                master_sel,
  input  logic                l_cs,
  input  logic                l_we,
  input  logic                l_oe,
  input  logic                l_ub,
  input  logic                l_lb,
  input  logic [ADDR_W-1:0]   l_addr,
  input  logic [2*LANE_W-1:0] l_wdata,
  output logic [2*LANE_W-1:0] l_rdata,
  input  logic                l_busy_in,
  output logic                l_busy_out,
  input  logic                r_cs,
  input  logic                r_we,
  input  logic                r_oe,
  input  logic                r_ub,
  input  logic                r_lb,
  input  logic [ADDR_W-1:0]   r_addr,
  input  logic [2*LANE_W-1:0] r_wdata,
  output logic [2*LANE_W-1:0] r_rdata,
  input  logic                r_busy_in,
  output logic                r_busy_out
);
  localparam int DATA_W = 2 * LANE_W;

  logic                   clash, lose_l, lose_r;
  logic [1:0]             cs_v, we_v, oe_v, ub_v, lb_v, block, wr_fire, rd_fire;
  logic [1:0][ADDR_W-1:0] addr_v;
  logic [1:0][DATA_W-1:0] wdata_v, mask_v, q_v, rdata_v;

  assign cs_v    = {r_cs, l_cs};
  assign we_v    = {r_we, l_we};
  assign oe_v    = {r_oe, l_oe};
  assign ub_v    = {r_ub, l_ub};
  assign lb_v    = {r_lb, l_lb};
  assign addr_v  = {r_addr, l_addr};
  assign wdata_v = {r_wdata, l_wdata};

  dparb_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .cs_l(l_cs), .cs_r(r_cs), .we_l(l_we), .we_r(r_we),
    .addr_l(l_addr), .addr_r(r_addr),
    .clash_o(clash), .lose_l_o(lose_l), .lose_r_o(lose_r)
  );

  assign block[0]   = master_sel ? lose_l : l_busy_in;
  assign block[1]   = master_sel ? lose_r : r_busy_in;
  assign l_busy_out = master_sel & lose_l;
  assign r_busy_out = master_sel & lose_r;

  for (genvar p = 0; p < 2; p++) begin : g_port
    dparb_port #(.LANE_W(LANE_W)) u_port (
      .clk(clk), .rst_n(rst_n),
      .cs(cs_v[p]), .we(we_v[p]), .oe(oe_v[p]), .ub(ub_v[p]), .lb(lb_v[p]),
      .block(block[p]), .word_q(q_v[p]),
      .wr_fire(wr_fire[p]), .rd_fire(rd_fire[p]),
      .wr_mask(mask_v[p]), .rdata(rdata_v[p])
    );
  end

  dparb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .wr(wr_fire), .rd(rd_fire), .addr(addr_v),
    .wdata(wdata_v), .mask(mask_v), .q(q_v)
  );

  assign l_rdata = rdata_v[0];
  assign r_rdata = rdata_v[1];

endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_sel,
  input logic              l_cs,
  input logic              l_we,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_busy_in,
  input logic              l_busy_out,
  input logic              r_cs,
  input logic              r_we,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy_in,
  input logic              r_busy_out,
  input logic              clash,
  input logic [1:0]        wr_fire
);

  // R4
  busy_needs_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy_out || r_busy_out) |-> (l_cs && r_cs && (l_addr == r_addr) && (l_we || r_we)));

  // R6
  single_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && clash) |-> ($countones({l_busy_out, r_busy_out}) == 1));

  // R6
  left_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && l_cs && r_cs && (l_addr == r_addr) && (l_we || r_we) && $past(!l_cs && !r_cs))
    |-> r_busy_out);

  // R7
  loser_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && $past(master_sel) && $past(l_busy_out || r_busy_out) && clash
     && $stable(l_addr) && $stable(r_addr))
    |-> ($stable(l_busy_out) && $stable(r_busy_out)));

  // R8
  left_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel ? l_busy_out : l_busy_in) |-> !wr_fire[0]);

  // R8
  right_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel ? r_busy_out : r_busy_in) |-> !wr_fire[1]);

  // R10
  slave_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> (!l_busy_out && !r_busy_out));

endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
  .l_cs(l_cs), .l_we(l_we), .l_addr(l_addr), .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
  .r_cs(r_cs), .r_we(r_we), .r_addr(r_addr), .r_busy_in(r_busy_in), .r_busy_out(r_busy_out),
  .clash(clash), .wr_fire(wr_fire)
);

// File: tb/dpram_arb_bench.sv
module dpram_arb_bench;
  localparam int AW = 4;
  localparam int LW = 8;
  localparam int DW = 2 * LW;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_sel = 1'b1;
  logic l_cs = 0, l_we = 0, l_oe = 1, l_ub = 0, l_lb = 0, l_busy_in = 0;
  logic r_cs = 0, r_we = 0, r_oe = 1, r_ub = 0, r_lb = 0, r_busy_in = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_out, r_busy_out;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] mdl [N];
  logic [DW-1:0] old_v;

  always #2 clk = ~clk;

  dpram_arb #(.ADDR_W(AW), .LANE_W(LW)) u_dpram_arb (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
    .l_cs(l_cs), .l_we(l_we), .l_oe(l_oe), .l_ub(l_ub), .l_lb(l_lb),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
    .r_cs(r_cs), .r_we(r_we), .r_oe(r_oe), .r_ub(r_ub), .r_lb(r_lb),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 16'h1357) ^ 16'hC3A5);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drv_l(input logic cs, input logic we, input logic ub, input logic lb,
                       input int a, input logic [DW-1:0] d);
    l_cs = cs; l_we = we; l_ub = ub; l_lb = lb; l_addr = AW'(a); l_wdata = d;
  endtask

  task automatic drv_r(input logic cs, input logic we, input logic ub, input logic lb,
                       input int a, input logic [DW-1:0] d);
    r_cs = cs; r_we = we; r_ub = ub; r_lb = lb; r_addr = AW'(a); r_wdata = d;
  endtask

  task automatic idle();
    drv_l(0, 0, 0, 0, 0, '0);
    drv_r(0, 0, 0, 0, 0, '0);
  endtask

  task automatic busy_is(input string req, input logic lb_exp, input logic rb_exp);
    #1;
    chk({req, " l_busy"}, DW'(l_busy_out), DW'(lb_exp));
    chk({req, " r_busy"}, DW'(r_busy_out), DW'(rb_exp));
  endtask

  // read address a on both ports, full lanes, check both returns
  task automatic read_both(input string req, input int a);
    tick(); drv_l(1, 0, 1, 1, a, '0); drv_r(1, 0, 1, 1, a, '0);
    tick(); idle(); #1;
    chk({req, " l_rdata"}, l_rdata, mdl[a]);
    chk({req, " r_rdata"}, r_rdata, mdl[a]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: outputs during reset
    chk("R11 busy in reset", DW'({l_busy_out, r_busy_out}), '0);
    chk("R11 l_rdata in reset", l_rdata, '0);
    rst_n = 1'b1;
    tick(); #1;
    chk("R11 r_rdata after reset", r_rdata, '0);

    // R1 / R4: fill every word from the left, no collision possible
    for (int a = 0; a < N; a++) begin
      tick(); idle(); drv_l(1, 1, 1, 1, a, pat(a)); mdl[a] = pat(a);
      busy_is("R4 lone write", 0, 0);
    end
    // R2: both ports read each word together
    for (int a = 0; a < N; a++) begin
      tick(); drv_l(1, 0, 1, 1, a, '0); drv_r(1, 0, 1, 1, a, '0);
      busy_is("R2 shared read", 0, 0);
      tick(); idle(); #1;
      chk("R2 R1 l_rdata", l_rdata, mdl[a]);
      chk("R2 R1 r_rdata", r_rdata, mdl[a]);
    end
    // R1: refill from the right with inverted pattern, read back
    for (int a = 0; a < N; a++) begin
      tick(); idle(); drv_r(1, 1, 1, 1, a, ~pat(a)); mdl[a] = ~pat(a);
    end
    for (int a = 0; a < N; a++) read_both("R1 right fill", a);

    // R1: output enable low forces zero
    tick(); drv_l(1, 0, 1, 1, 3, '0);
    tick(); idle(); l_oe = 0; #1;
    chk("R1 oe low", l_rdata, '0);
    l_oe = 1; #1;
    chk("R1 oe high", l_rdata, mdl[3]);

    // R3: upper-lane write on left, lower-lane write on right
    tick(); idle(); drv_l(1, 1, 1, 0, 3, 16'hBEEF); mdl[3] = {8'hBE, mdl[3][7:0]};
    tick(); idle(); drv_r(1, 1, 0, 1, 5, 16'h1234); mdl[5] = {mdl[5][15:8], 8'h34};
    read_both("R3 upper lane", 3);
    read_both("R3 lower lane", 5);
    tick(); idle(); drv_r(1, 0, 1, 0, 5, '0);
    tick(); idle(); #1;
    chk("R3 masked read", r_rdata, {mdl[5][15:8], 8'h00});

    // R4: writes to different words in the same cycle, no busy
    tick(); drv_l(1, 1, 1, 1, 10, 16'h0A0A); drv_r(1, 1, 1, 1, 11, 16'h0B0B);
    mdl[10] = 16'h0A0A; mdl[11] = 16'h0B0B;
    busy_is("R4 distinct words", 0, 0);
    read_both("R4 distinct word l", 10);
    read_both("R4 distinct word r", 11);

    // R6 / R8: simultaneous writes to one word, left wins
    tick(); idle();
    tick(); drv_l(1, 1, 1, 1, 7, 16'h1111); drv_r(1, 1, 1, 1, 7, 16'h2222);
    mdl[7] = 16'h1111;
    busy_is("R6 tie", 0, 1);
    tick(); idle();
    busy_is("R7 clear after", 0, 0);
    read_both("R8 tie result", 7);

    // R5 / R7 / R8: right parked first, left arrives and loses
    tick(); idle(); drv_r(1, 1, 1, 1, 9, 16'hAAAA); mdl[9] = 16'hAAAA;
    busy_is("R5 parked alone", 0, 0);
    tick(); drv_l(1, 1, 1, 1, 9, 16'h5555);
    busy_is("R5 newcomer left", 1, 0);
    tick();
    busy_is("R7 held loser", 1, 0);
    tick(); idle();
    busy_is("R7 clear", 0, 0);
    read_both("R8 parked writer", 9);

    // R5 / R9: left parked reading, right arrives writing and loses
    tick(); idle(); drv_l(1, 0, 1, 1, 2, '0);
    tick(); drv_r(1, 1, 1, 1, 2, 16'hDEAD);
    busy_is("R5 newcomer right", 0, 1);
    tick(); idle(); #1;
    chk("R9 winner read", l_rdata, mdl[2]);
    read_both("R8 dropped right write", 2);

    // R9: fresh tie, left writes, right reads and loses, sees old word
    old_v = mdl[6];
    tick(); idle();
    tick(); drv_l(1, 1, 1, 1, 6, 16'h6060); drv_r(1, 0, 1, 1, 6, '0);
    mdl[6] = 16'h6060;
    busy_is("R9 reader loses", 0, 1);
    tick(); idle(); #1;
    chk("R9 loser read old", r_rdata, old_v);
    read_both("R8 winner write", 6);

    // R9: fresh tie, left reads and wins, right write dropped
    tick(); idle();
    tick(); drv_l(1, 0, 1, 1, 4, '0); drv_r(1, 1, 1, 1, 4, 16'h4444);
    busy_is("R9 writer loses", 0, 1);
    tick(); idle(); #1;
    chk("R9 left read", l_rdata, mdl[4]);
    read_both("R8 dropped write", 4);

    // R10: slave mode
    master_sel = 0;
    tick(); idle();
    tick(); l_busy_in = 1; drv_l(1, 1, 1, 1, 12, 16'hC0C0); drv_r(1, 1, 1, 1, 12, 16'hC1C1);
    mdl[12] = 16'hC1C1;
    busy_is("R10 slave outputs", 0, 0);
    tick(); idle(); drv_l(1, 1, 1, 1, 13, 16'hD0D0);
    tick(); idle(); drv_l(1, 0, 1, 1, 12, '0);
    tick(); idle(); #1;
    chk("R10 read with busy_in", l_rdata, mdl[12]);
    l_busy_in = 0; r_busy_in = 1;
    tick(); idle(); drv_r(1, 1, 1, 1, 14, 16'hE0E0);
    tick(); idle(); r_busy_in = 0;
    read_both("R10 left blocked", 13);
    read_both("R10 right blocked", 14);
    read_both("R10 right landed", 12);
    // R10: busy inputs ignored in master mode
    master_sel = 1; l_busy_in = 1;
    tick(); idle(); drv_l(1, 1, 1, 1, 15, 16'hF00F); mdl[15] = 16'hF00F;
    tick(); idle(); l_busy_in = 0;
    read_both("R10 master ignores busy_in", 15);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule